// File: doc/BRIEF.md
# Scaled radix-2 frequency-split butterfly

This block is the arithmetic core of one stage in a pipelined radix-2 decimation-in-frequency transform. It takes two complex 8-bit operands, A and B, and one complex 8-bit twiddle factor, W. It returns two results: the sum A+B, and the difference A−B rotated by W. Both are reduced back to 8 bits. The twiddle source and the routing of data between stages are outside this block.

Each result is divided by two, so that a cascade of stages cannot overflow. A chain of six stages therefore has a total gain of 1/64. The division rounds half up: one is added at the discarded half-LSB position before the arithmetic shift.

The twiddle is a signed fixed-point value with 6 fractional bits, so 64 represents 1.0. The rotated difference is first truncated (floor) by 6 bits into a 16-bit intermediate. It is then halved with rounding and clipped to the signed 8-bit range. All four results come out of registers, one clock after the operands are presented.

Top module: `bfly_dif_scaled`

## Requirements
- R1: While `rst_ni` is low, all four outputs are 0.
- R2: For each component c in {re, im}, `sum_c_o = floor((a_c + b_c + 1) / 2)`, with all values treated as signed two's complement.
- R3: The difference is `d = a − b`, taken per component. The rotated real part is `pr = dr·wr − di·wi`. The rotated imaginary part is `pi = dr·wi + di·wr`.
- R4: Each rotated part p is reduced to `q = floor(p / 64)`, held as a signed 16-bit intermediate. The output is then `dif_c_o = floor((q + 1) / 2)` before clipping.
- R5: A rounded difference result above 127 is output as 127. One below −128 is output as −128.
- R6: The outputs reflect the inputs sampled at the previous rising clock edge. If the inputs do not change, the outputs do not change.
- R7: If A equals B, or if W is zero, both difference outputs are 0 one cycle later.
- R8: The sum outputs never clip. Operands 127 and 127 give 127, and −128 and −128 give −128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_re_i | input | 8 | Operand A, real part, signed |
| a_im_i | input | 8 | Operand A, imaginary part, signed |
| b_re_i | input | 8 | Operand B, real part, signed |
| b_im_i | input | 8 | Operand B, imaginary part, signed |
| w_re_i | input | 8 | Twiddle real part, signed, 6 fractional bits |
| w_im_i | input | 8 | Twiddle imaginary part, signed, 6 fractional bits |
| sum_re_o | output | 8 | Halved sum, real part |
| sum_im_o | output | 8 | Halved sum, imaginary part |
| dif_re_o | output | 8 | Halved rotated difference, real part |
| dif_im_o | output | 8 | Halved rotated difference, imaginary part |

## Verification
Small hand-picked operands with unit, quarter-turn and zero twiddles separate sign errors and real/imaginary swaps in the complex product. Odd positive and negative sums expose the half-up rounding rule and show a truncating shift for what it is. Extreme operands drive the rotated difference past both clip limits, and the sum to its two corners, which tells wrap-around apart from saturation. A long run of random operands, each compared cycle by cycle against an integer model, covers the one-cycle alignment and the general arithmetic.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  typedef enum logic [1:0] {
    LANE_SUM_RE = 2'd0,
    LANE_SUM_IM = 2'd1,
    LANE_DIF_RE = 2'd2,
    LANE_DIF_IM = 2'd3
  } lane_e;

  localparam int NUM_LANES = 4;
endpackage

// File: rtl/bfly_addsub.sv
module bfly_addsub #(
  parameter int DATA_W = 8,
  localparam int EXT_W = DATA_W + 1
) (
  input  logic signed [DATA_W-1:0] a_re_i,
  input  logic signed [DATA_W-1:0] a_im_i,
  input  logic signed [DATA_W-1:0] b_re_i,
  input  logic signed [DATA_W-1:0] b_im_i,
  output logic signed [EXT_W-1:0]  sum_re_o,
  output logic signed [EXT_W-1:0]  sum_im_o,
  output logic signed [EXT_W-1:0]  dif_re_o,
  output logic signed [EXT_W-1:0]  dif_im_o
);
  assign sum_re_o = EXT_W'(a_re_i) + EXT_W'(b_re_i);
  assign sum_im_o = EXT_W'(a_im_i) + EXT_W'(b_im_i);
  assign dif_re_o = EXT_W'(a_re_i) - EXT_W'(b_re_i);
  assign dif_im_o = EXT_W'(a_im_i) - EXT_W'(b_im_i);
endmodule

// File: rtl/bfly_cmul.sv
module bfly_cmul #(
  parameter int IN_W   = 9,
  parameter int TW_W   = 8,
  parameter int FRAC_W = 6,
  parameter int MID_W  = 16,
  localparam int PROD_W = IN_W + TW_W + 1
) (
  input  logic signed [IN_W-1:0]  d_re_i,
  input  logic signed [IN_W-1:0]  d_im_i,
  input  logic signed [TW_W-1:0]  w_re_i,
  input  logic signed [TW_W-1:0]  w_im_i,
  output logic signed [MID_W-1:0] q_re_o,
  output logic signed [MID_W-1:0] q_im_o
);
  logic signed [PROD_W-1:0] dr, di, wr, wi;
  logic signed [PROD_W-1:0] p_re, p_im, s_re, s_im;

  assign dr = PROD_W'(d_re_i);
  assign di = PROD_W'(d_im_i);
  assign wr = PROD_W'(w_re_i);
  assign wi = PROD_W'(w_im_i);

  // full-precision rotation, four real multiplies
  assign p_re = dr * wr - di * wi;
  assign p_im = dr * wi + di * wr;

  // drop twiddle fraction (floor)
  assign s_re = p_re >>> FRAC_W;
  assign s_im = p_im >>> FRAC_W;

  assign q_re_o = MID_W'(s_re);
  assign q_im_o = MID_W'(s_im);
endmodule

// File: rtl/bfly_round_sat.sv
module bfly_round_sat #(
  parameter int MID_W = 16,
  parameter int OUT_W = 8,
  localparam int RW   = MID_W + 1
) (
  input  logic signed [MID_W-1:0] x_i,
  output logic signed [OUT_W-1:0] y_o
);
  localparam logic signed [RW-1:0] HALF   = RW'(1);
  localparam logic signed [RW-1:0] SAT_HI = RW'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [RW-1:0] SAT_LO = ~SAT_HI;

  logic signed [RW-1:0] biased, halved;

  assign biased = RW'(x_i) + HALF;
  assign halved = biased >>> 1;

  always_comb begin
    if (halved > SAT_HI)      y_o = SAT_HI[OUT_W-1:0];
    else if (halved < SAT_LO) y_o = SAT_LO[OUT_W-1:0];
    else                      y_o = halved[OUT_W-1:0];
  end
endmodule

// File: rtl/bfly_dif_scaled.sv
module bfly_dif_scaled
  import bfly_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FRAC_W = 6,
  parameter int MID_W  = 16,
  localparam int EXT_W = DATA_W + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [DATA_W-1:0] a_re_i,
  input  logic signed [DATA_W-1:0] a_im_i,
  input  logic signed [DATA_W-1:0] b_re_i,
  input  logic signed [DATA_W-1:0] b_im_i,
  input  logic signed [DATA_W-1:0] w_re_i,
  input  logic signed [DATA_W-1:0] w_im_i,
  output logic signed [DATA_W-1:0] sum_re_o,
  output logic signed [DATA_W-1:0] sum_im_o,
  output logic signed [DATA_W-1:0] dif_re_o,
  output logic signed [DATA_W-1:0] dif_im_o
);
  logic signed [EXT_W-1:0]  s_re, s_im, d_re, d_im;
  logic signed [MID_W-1:0]  q_re, q_im;
  logic signed [MID_W-1:0]  mid  [NUM_LANES];
  logic signed [DATA_W-1:0] red  [NUM_LANES];
  logic signed [DATA_W-1:0] oreg [NUM_LANES];

  bfly_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_re_i  (a_re_i),
    .a_im_i  (a_im_i),
    .b_re_i  (b_re_i),
    .b_im_i  (b_im_i),
    .sum_re_o(s_re),
    .sum_im_o(s_im),
    .dif_re_o(d_re),
    .dif_im_o(d_im)
  );

  bfly_cmul #(
    .IN_W  (EXT_W),
    .TW_W  (DATA_W),
    .FRAC_W(FRAC_W),
    .MID_W (MID_W)
  ) u_cmul (
    .d_re_i(d_re),
    .d_im_i(d_im),
    .w_re_i(w_re_i),
    .w_im_i(w_im_i),
    .q_re_o(q_re),
    .q_im_o(q_im)
  );

  assign mid[int'(LANE_SUM_RE)] = MID_W'(s_re);
  assign mid[int'(LANE_SUM_IM)] = MID_W'(s_im);
  assign mid[int'(LANE_DIF_RE)] = q_re;
  assign mid[int'(LANE_DIF_IM)] = q_im;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    bfly_round_sat #(.MID_W(MID_W), .OUT_W(DATA_W)) u_rs (
      .x_i(mid[l]),
      .y_o(red[l])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int l = 0; l < NUM_LANES; l++) oreg[l] <= '0;
    end else begin
      for (int l = 0; l < NUM_LANES; l++) oreg[l] <= red[l];
    end
  end

  assign sum_re_o = oreg[int'(LANE_SUM_RE)];
  assign sum_im_o = oreg[int'(LANE_SUM_IM)];
  assign dif_re_o = oreg[int'(LANE_DIF_RE)];
  assign dif_im_o = oreg[int'(LANE_DIF_IM)];

  localparam logic signed [DATA_W-1:0] D_MAX = DATA_W'((2 ** (DATA_W - 1)) - 1);
  localparam logic signed [DATA_W-1:0] D_MIN = ~D_MAX;

  // R7
  equal_ops_zero_dif_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_re_i == b_re_i && a_im_i == b_im_i) |=> (dif_re_o == '0 && dif_im_o == '0));

  // R7
  zero_tw_zero_dif_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_re_i == '0 && w_im_i == '0) |=> (dif_re_o == '0 && dif_im_o == '0));

  // R8
  sum_top_corner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_re_i == D_MAX && b_re_i == D_MAX) |=> (sum_re_o == D_MAX));

  // R8
  sum_low_corner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_im_i == D_MIN && b_im_i == D_MIN) |=> (sum_im_o == D_MIN));

  // R2
  opposite_ops_zero_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_re_i != D_MIN && a_re_i == -b_re_i) |=> (sum_re_o == '0));

  // R6
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $stable({a_re_i, a_im_i, b_re_i, b_im_i, w_re_i, w_im_i}))
      |=> $stable({sum_re_o, sum_im_o, dif_re_o, dif_im_o}));
endmodule

// File: tb/sim_bfly_dif_scaled.sv
`timescale 1ns/1ps
module sim_bfly_dif_scaled;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [7:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0, w_re = '0, w_im = '0;
  logic signed [7:0] sum_re, sum_im, dif_re, dif_im;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bfly_dif_scaled u0 (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .a_re_i  (a_re),
    .a_im_i  (a_im),
    .b_re_i  (b_re),
    .b_im_i  (b_im),
    .w_re_i  (w_re),
    .w_im_i  (w_im),
    .sum_re_o(sum_re),
    .sum_im_o(sum_im),
    .dif_re_o(dif_re),
    .dif_im_o(dif_im)
  );

  function automatic int halve_clip(int x);
    int h = (x + 1) >>> 1;
    if (h > 127) h = 127;
    if (h < -128) h = -128;
    return h;
  endfunction

  task automatic chk(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  int exp_q[$];

  // drive one vector at a falling edge, compare one cycle later
  task automatic apply(int ar, int ai, int br, int bi, int wr, int wi, string tag);
    int dr, di, pr, pi;
    a_re = 8'(ar); a_im = 8'(ai); b_re = 8'(br); b_im = 8'(bi); w_re = 8'(wr); w_im = 8'(wi);
    dr = int'(a_re) - int'(b_re);
    di = int'(a_im) - int'(b_im);
    pr = dr * int'(w_re) - di * int'(w_im);
    pi = dr * int'(w_im) + di * int'(w_re);
    exp_q.push_back(halve_clip(int'(a_re) + int'(b_re)));
    exp_q.push_back(halve_clip(int'(a_im) + int'(b_im)));
    exp_q.push_back(halve_clip(pr >>> 6));
    exp_q.push_back(halve_clip(pi >>> 6));
    @(negedge clk);
    chk(int'(sum_re), exp_q.pop_front(), {tag, " sum_re"});
    chk(int'(sum_im), exp_q.pop_front(), {tag, " sum_im"});
    chk(int'(dif_re), exp_q.pop_front(), {tag, " dif_re"});
    chk(int'(dif_im), exp_q.pop_front(), {tag, " dif_im"});
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic signed [7:0] h_re, h_im;
    a_re = 8'sd50; b_re = 8'sd40; w_re = 8'sd64;
    repeat (3) @(negedge clk);
    // R1 reset holds outputs at zero despite nonzero inputs
    chk(int'(sum_re), 0, "R1 sum_re");
    chk(int'(dif_re), 0, "R1 dif_re");
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 unit twiddle
    apply(10, 0, 4, 0, 64, 0, "R3 unit_tw");
    // R3 quarter turn: (dr,di)*(0,64) -> (-di, dr)
    apply(20, 6, 4, -10, 0, 64, "R3 quarter_tw");
    apply(20, 6, 4, -10, 0, -64, "R3 neg_quarter_tw");
    // R2 rounding half up on odd sums
    apply(2, -2, 1, -1, 0, 0, "R2 odd_sum");
    apply(-1, 1, 0, 0, 0, 0, "R2 minus_one");
    // R4 floor by 64 then halve: p=100 -> q=1 -> 1; p=-1 -> q=-1 -> 0
    apply(100, 0, 0, 0, 1, 0, "R4 floor_pos");
    apply(-1, 0, 0, 0, 1, 0, "R4 floor_neg");
    apply(3, 0, 0, 0, 64, 0, "R4 halve_odd");
    // R5 clip high and low
    apply(127, -128, -128, 127, -128, -128, "R5 clip_low");
    apply(127, -128, -128, 127, 127, 127, "R5 clip_mix");
    apply(-128, 127, 127, -128, -128, -128, "R5 clip_high");
    // R7 equal operands, zero twiddle
    apply(77, -33, 77, -33, 100, -90, "R7 equal_ops");
    apply(90, -90, -90, 90, 0, 0, "R7 zero_tw");
    // R8 sum corners
    apply(127, -128, 127, -128, 64, 0, "R8 corners");
    // R6 hold: same vector twice, outputs unchanged
    apply(33, -71, -5, 19, 45, -45, "R6 first");
    h_re = dif_re; h_im = sum_im;
    apply(33, -71, -5, 19, 45, -45, "R6 repeat");
    chk(int'(dif_re), int'(h_re), "R6 hold dif_re");
    chk(int'(sum_im), int'(h_im), "R6 hold sum_im");

    for (int i = 0; i < 3000; i++) begin
      apply($signed(8'($urandom)), $signed(8'($urandom)), $signed(8'($urandom)),
            $signed(8'($urandom)), $signed(8'($urandom)), $signed(8'($urandom)),
            "R2 R3 R4 R5 random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule